// File: doc/BRIEF.md
# Transmit Buffer Status Controller

This block keeps the transmit state of one message buffer in a CAN-style controller and decides when that buffer asks to be sent. A host writes a 4-bit status code and, while the buffer is inactive, loads an identifier (with its remote-request flag) and up to eight data bytes. The protocol engine reports three events back: a matching remote frame was received, the frame was sent, or the transfer was aborted by an error.

Three sending modes exist. Single-shot sends one frame and goes back to inactive. Single-shot-then-reply sends one frame and then waits for remote frames. Reply-only waits for a remote frame and answers it with no host action. While a transfer is pending, the busy flag raises the transmit request and locks out every host write. A successful send gives a one-cycle completion interrupt. Choosing between buffers and the bus protocol itself belong to other blocks.

Top module: `txbuf_status_ctrl`

## Requirements
- R1: After reset the status reads 4'b0000 (inactive), transmit request, busy and interrupt are low, and the identifier, remote flag and data bytes are all zero.
- R2: While not busy, a status write whose code with bit 0 cleared is 4'b0100 (single-shot) makes the status 4'b0101 on the next cycle. Busy and the transmit request are then high. Busy is always status bit 0, and the transmit request always equals busy.
- R3: While not busy, a status write whose masked code is 4'b0110 (single-shot-then-reply) makes the status 4'b0111 (busy). When that transfer ends, the status becomes 4'b0010 (waiting for remote).
- R4: In status 4'b0010 the block is not busy and does not request. A remote-frame hit moves it to 4'b0011 (busy, requesting), and the end of that transfer returns it to 4'b0010. A remote-frame hit in any other status is ignored.
- R5: Identifier, remote-flag and data-byte writes take effect on the next cycle only when the status is 4'b0000. In any other status they are ignored. A byte write uses its select value as the byte index (byte i occupies frameData bits 8i+7..8i), and a select value of DATA_BYTES or more writes nothing.
- R6: Bit 0 of a written status code is ignored, so the host can never set busy directly. Any masked code other than 4'b0000, 4'b0010, 4'b0100 or 4'b0110 is taken as 4'b0000.
- R7: Status writes made while busy are ignored.
- R8: A send-done while busy clears busy on the next cycle. The status goes to 4'b0010 if status bit 1 was set and to 4'b0000 otherwise. irqDone is high for exactly that one cycle.
- R9: An abort while busy clears busy in the same way as R8 but raises no interrupt. If send-done and abort arrive together, send-done wins.
- R10: Send-done and abort are ignored while not busy: no status change and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostStatWr | input | 1 | Host status write strobe |
| hostStatCode | input | 4 | Status code written by the host |
| hostIdWr | input | 1 | Host identifier write strobe |
| hostId | input | ID_W | Identifier value |
| hostRtr | input | 1 | Remote-request flag written with the identifier |
| hostByteWr | input | 1 | Host data byte write strobe |
| hostByteSel | input | SEL_W | Data byte index |
| hostByte | input | 8 | Data byte value |
| rtrHit | input | 1 | Matching remote frame received |
| txDone | input | 1 | Frame sent successfully |
| txAbort | input | 1 | Transfer aborted by error |
| statusOut | output | 4 | Current status code |
| txReq | output | 1 | Transmit request |
| busy | output | 1 | Buffer locked, transfer pending |
| irqDone | output | 1 | One-cycle completion interrupt |
| frameId | output | ID_W | Stored identifier |
| frameRtr | output | 1 | Stored remote-request flag |
| frameData | output | 8*DATA_BYTES | Stored data bytes, byte 0 in the low bits |

## Verification
The bench writes all sixteen status codes from the inactive state. This separates the four legal modes from the masked busy bit and the illegal codes. Each code is followed by each of the three ending events (send-done, abort, both together), which shows the interrupt rule, the done-over-abort priority and the mode-dependent return status. In the busy and armed states it also tries identifier and status writes, remote hits and stray done/abort pulses, to show that the lockout holds and that events outside their state are ignored. A separate pass over every byte index, including one past the end, checks where data bytes land.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

  localparam int STAT_W = 4;

  localparam logic [STAT_W-1:0] ST_IDLE      = 4'b0000;
  localparam logic [STAT_W-1:0] ST_AWAIT     = 4'b0010;
  localparam logic [STAT_W-1:0] ST_ONCE      = 4'b0100;
  localparam logic [STAT_W-1:0] ST_ONCE_AWT  = 4'b0110;
  localparam int               BUSY_BIT     = 0;
  localparam int               RETURN_BIT   = 1;

  typedef struct packed {
    logic loadId;
    logic loadByte;
  } dpStrobe_t;

endpackage

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
  import txbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStatWr,
  input  logic [STAT_W-1:0] hostStatCode,
  input  logic              hostIdWr,
  input  logic              hostByteWr,
  input  logic              rtrHit,
  input  logic              txDone,
  input  logic              txAbort,
  output logic [STAT_W-1:0] statReg,
  output logic              irqDone,
  output dpStrobe_t         strobe
);

  logic [STAT_W-1:0] maskedCode;
  logic [STAT_W-1:0] decodedStat;
  logic [STAT_W-1:0] releaseStat;
  logic [STAT_W-1:0] statNext;
  logic              isBusy;
  logic              isIdle;
  logic              ending;

  assign isBusy     = statReg[BUSY_BIT];
  assign isIdle     = (statReg == ST_IDLE);
  assign maskedCode = hostStatCode & ~(STAT_W'(1) << BUSY_BIT);
  assign ending     = txDone || txAbort;

  // Host code decode: the busy bit of the written value never lands
  always_comb begin
    case (maskedCode)
      ST_ONCE:     decodedStat = ST_ONCE | STAT_W'(1);
      ST_ONCE_AWT: decodedStat = ST_ONCE_AWT | STAT_W'(1);
      ST_AWAIT:    decodedStat = ST_AWAIT;
      default:     decodedStat = ST_IDLE;
    endcase
  end

  // After a transfer, modes that answer remote frames keep waiting
  assign releaseStat = statReg[RETURN_BIT] ? ST_AWAIT : ST_IDLE;

  always_comb begin
    statNext = statReg;
    if (isBusy) begin
      if (ending) statNext = releaseStat;
    end else if (hostStatWr) begin
      statNext = decodedStat;
    end else if (rtrHit && statReg == ST_AWAIT) begin
      statNext = ST_AWAIT | STAT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= ST_IDLE;
      irqDone <= 1'b0;
    end else begin
      statReg <= statNext;
      irqDone <= isBusy && txDone;
    end
  end

  always_comb begin
    strobe.loadId   = hostIdWr && isIdle;
    strobe.loadByte = hostByteWr && isIdle;
  end

  // R2: a single-shot write from a free buffer makes it busy next cycle
  a_r2_once_goes_busy: assert property (@(posedge clk) disable iff (!rstN)
    (hostStatWr && !isBusy && maskedCode == ST_ONCE) |=> (statReg == 4'b0101));

  // R6: the host cannot set the busy bit alone
  a_r6_busy_bit_masked: assert property (@(posedge clk) disable iff (!rstN)
    (hostStatWr && !isBusy && hostStatCode == 4'b0001) |=> (statReg == ST_IDLE));

  // R7: status writes made while busy change nothing
  a_r7_busy_write_lock: assert property (@(posedge clk) disable iff (!rstN)
    (isBusy && hostStatWr && !ending) |=> $stable(statReg));

  // R8: the interrupt is a single-cycle pulse
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqDone |=> !irqDone);

  // R9: an abort alone frees the buffer without an interrupt
  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (isBusy && txAbort && !txDone) |=> (!irqDone && !statReg[BUSY_BIT]));

  // R10: no interrupt can follow a cycle that was not busy
  a_r10_no_irq_idle: assert property (@(posedge clk) disable iff (!rstN)
    !isBusy |=> !irqDone);

endmodule

// File: rtl/txbuf_data.sv
module txbuf_data
  import txbuf_pkg::*;
#(
  parameter int ID_W       = 11,
  parameter int DATA_BYTES = 8,
  parameter int SEL_W      = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic [ID_W-1:0]         hostId,
  input  logic                    hostRtr,
  input  logic [SEL_W-1:0]        hostByteSel,
  input  logic [7:0]              hostByte,
  output logic [ID_W-1:0]         frameId,
  output logic                    frameRtr,
  output logic [8*DATA_BYTES-1:0] frameData
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameId  <= '0;
      frameRtr <= 1'b0;
    end else if (strobe.loadId) begin
      frameId  <= hostId;
      frameRtr <= hostRtr;
    end
  end

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
    logic hit;
    assign hit = strobe.loadByte && (int'(hostByteSel) == b);
    always_ff @(posedge clk) begin
      if (!rstN)    frameData[8*b +: 8] <= 8'h00;
      else if (hit) frameData[8*b +: 8] <= hostByte;
    end
  end

endmodule

// File: rtl/txbuf_status_ctrl.sv
module txbuf_status_ctrl
  import txbuf_pkg::*;
#(
  parameter int ID_W       = 11,
  parameter int DATA_BYTES = 8,
  localparam int SEL_W     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES + 1) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hostStatWr,
  input  logic [3:0]              hostStatCode,
  input  logic                    hostIdWr,
  input  logic [ID_W-1:0]         hostId,
  input  logic                    hostRtr,
  input  logic                    hostByteWr,
  input  logic [SEL_W-1:0]        hostByteSel,
  input  logic [7:0]              hostByte,
  input  logic                    rtrHit,
  input  logic                    txDone,
  input  logic                    txAbort,
  output logic [3:0]              statusOut,
  output logic                    txReq,
  output logic                    busy,
  output logic                    irqDone,
  output logic [ID_W-1:0]         frameId,
  output logic                    frameRtr,
  output logic [8*DATA_BYTES-1:0] frameData
);

  dpStrobe_t strobe;
  logic [STAT_W-1:0] statReg;

  txbuf_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .hostStatWr   (hostStatWr),
    .hostStatCode (hostStatCode),
    .hostIdWr     (hostIdWr),
    .hostByteWr   (hostByteWr),
    .rtrHit       (rtrHit),
    .txDone       (txDone),
    .txAbort      (txAbort),
    .statReg      (statReg),
    .irqDone      (irqDone),
    .strobe       (strobe)
  );

  txbuf_data #(
    .ID_W       (ID_W),
    .DATA_BYTES (DATA_BYTES),
    .SEL_W      (SEL_W)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .hostId      (hostId),
    .hostRtr     (hostRtr),
    .hostByteSel (hostByteSel),
    .hostByte    (hostByte),
    .frameId     (frameId),
    .frameRtr    (frameRtr),
    .frameData   (frameData)
  );

  assign statusOut = statReg;
  assign busy      = statReg[BUSY_BIT];
  assign txReq     = statReg[BUSY_BIT];

  // R5: buffer contents cannot move while a transfer is pending
  a_r5_busy_content_lock: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(frameId) && $stable(frameRtr) && $stable(frameData)));

  // R4: a remote hit while waiting starts a request next cycle
  a_r4_remote_reply: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut == 4'b0010 && rtrHit && !hostStatWr) |=> (txReq && statusOut == 4'b0011));

endmodule

// File: tb/test_txbuf_status_ctrl.sv
module test_txbuf_status_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ID_W       = 11;
  localparam int DATA_BYTES = 8;
  localparam int SEL_W      = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostStatWr = 1'b0;
  logic [3:0] hostStatCode = '0;
  logic hostIdWr = 1'b0;
  logic [ID_W-1:0] hostId = '0;
  logic hostRtr = 1'b0;
  logic hostByteWr = 1'b0;
  logic [SEL_W-1:0] hostByteSel = '0;
  logic [7:0] hostByte = '0;
  logic rtrHit = 1'b0;
  logic txDone = 1'b0;
  logic txAbort = 1'b0;
  logic [3:0] statusOut;
  logic txReq, busy, irqDone, frameRtr;
  logic [ID_W-1:0] frameId;
  logic [8*DATA_BYTES-1:0] frameData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txbuf_status_ctrl #(.ID_W(ID_W), .DATA_BYTES(DATA_BYTES)) i_txbuf_status_ctrl (
    .clk(clk), .rstN(rstN), .hostStatWr(hostStatWr), .hostStatCode(hostStatCode),
    .hostIdWr(hostIdWr), .hostId(hostId), .hostRtr(hostRtr),
    .hostByteWr(hostByteWr), .hostByteSel(hostByteSel), .hostByte(hostByte),
    .rtrHit(rtrHit), .txDone(txDone), .txAbort(txAbort),
    .statusOut(statusOut), .txReq(txReq), .busy(busy), .irqDone(irqDone),
    .frameId(frameId), .frameRtr(frameRtr), .frameData(frameData)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    hostStatWr = 0; hostIdWr = 0; hostByteWr = 0;
    rtrHit = 0; txDone = 0; txAbort = 0;
  endtask

  task automatic writeStat(input logic [3:0] c);
    hostStatWr = 1; hostStatCode = c; step();
  endtask

  task automatic writeId(input logic [ID_W-1:0] v, input logic r);
    hostIdWr = 1; hostId = v; hostRtr = r; step();
  endtask

  // Expected status after a write from a free buffer (R2, R3, R4, R6)
  function automatic logic [3:0] expWrite(input logic [3:0] c);
    case (c & 4'hE)
      4'h4:    return 4'h5;
      4'h6:    return 4'h7;
      4'h2:    return 4'h2;
      default: return 4'h0;
    endcase
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1: reset values
    check("R1 status", statusOut, 4'h0);
    check("R1 txReq", txReq, 0);
    check("R1 busy", busy, 0);
    check("R1 irq", irqDone, 0);
    check("R1 id", {frameRtr, frameId}, 0);
    check("R1 data", frameData, 0);

    // R5: byte placement over every index, plus one out of range
    for (int b = 0; b <= DATA_BYTES; b++) begin
      hostByteWr = 1; hostByteSel = SEL_W'(b); hostByte = 8'hA0 + 8'(b); step();
    end
    for (int b = 0; b < DATA_BYTES; b++)
      check("R5 byte place", frameData[8*b +: 8], 8'hA0 + 8'(b));

    // R10: stray done/abort while inactive
    txDone = 1; step();
    check("R10 done idle irq", irqDone, 0);
    check("R10 done idle stat", statusOut, 4'h0);
    txAbort = 1; step();
    check("R10 abort idle stat", statusOut, 4'h0);
    // R4: remote hit ignored when inactive
    rtrHit = 1; step();
    check("R4 hit idle", statusOut, 4'h0);

    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 3; k++) begin
        logic [3:0] e;
        logic [ID_W-1:0] mark;
        mark = ID_W'(c * 3 + k + 1);
        e = expWrite(4'(c));
        writeId(mark, k[0]);
        check("R5 id load idle", {frameRtr, frameId}, {k[0], mark});
        writeStat(4'(c));
        check("R6 decode", statusOut, e);
        check("R2 req=busy", {txReq, busy}, {2{e[0]}});
        if (e[0]) begin
          // R5 and R7: lockout while busy
          writeId(~mark, ~k[0]);
          check("R5 id locked", {frameRtr, frameId}, {k[0], mark});
          writeStat(4'h0);
          check("R7 stat locked", statusOut, e);
          txDone = (k != 1); txAbort = (k != 0); step();
          check("R8 R9 irq", irqDone, (k != 1));
          check("R3 R8 release", statusOut, (e == 4'h7) ? 4'h2 : 4'h0);
          step();
          check("R8 pulse end", irqDone, 0);
        end
        if (statusOut == 4'h2) begin
          writeId(~mark, 1'b0);
          check("R5 id locked await", frameId, mark);
          txDone = 1; step();
          check("R10 done await", {irqDone, statusOut}, {1'b0, 4'h2});
          rtrHit = 1; step();
          check("R4 hit", {txReq, statusOut}, {1'b1, 4'h3});
          txDone = (k != 1); txAbort = (k == 1); step();
          check("R4 back to await", {irqDone, statusOut}, {(k != 1), 4'h2});
          writeStat(4'h0);
          check("R4 leave await", statusOut, 4'h0);
        end
      end
    end

    finishRun();
  end

endmodule